// File: doc/BRIEF.md
# Serial-Input FIR Level Classifier

This block takes unsigned 10-bit samples over a simple serial link. It filters them with a finite impulse response filter and sorts the filtered level into one of three bands, which it shows on two indicator outputs.

While the handshake is high, each rising edge of the serial clock shifts one bit into the sample register, least significant bit first. When the handshake falls, the system-clock side takes the finished sample once. It pushes the sample into a delay line and then runs one multiply-accumulate per system clock across all taps. When the sum is complete, it rescales the sum to an 8-bit signed level and updates the indicators.

The coefficients come from an internal formula. They are symmetric and scaled by 2^15.

Top module: `fir_level_classifier`

## Requirements
- R1: While `ser_hs` is high, each rising `ser_clk` edge shifts `sample_o` right by one place and loads `ser_bit` into bit 9. After ten edges, `sample_o` holds the word that was sent least significant bit first.
- R2: A rising `ser_clk` edge while `ser_hs` is low has no effect on `sample_o` or on the indicators.
- R3: Each low period of `ser_hs` starts exactly one filter evaluation, however long the low period lasts. The next evaluation needs `ser_hs` to have been seen high first.
- R4: An evaluation moves every delay-line entry one place older and puts the new sample at index 0. Tap k uses coefficient 2048 + 1024*min(k, NTAPS-1-k), where index 0 is the newest sample.
- R5: The level is bits 22 down to 15 of the 32-bit signed sum of the products, read as an 8-bit signed value. Higher bits are discarded.
- R6: A level from 40 to 60 inclusive sets `ind_hi_o`=0 and `ind_alt_o`=0.
- R7: A level from 90 to 110 inclusive sets `ind_hi_o`=1 and `ind_alt_o`=0.
- R8: Any other level sets `ind_hi_o`=0 and `ind_alt_o`=1. The two indicators are never both 1.
- R9: Until NTAPS evaluations have completed since reset, the outcome is `ind_hi_o`=0 and `ind_alt_o`=1, whatever the level.
- R10: An evaluation takes NTAPS system clocks of accumulation. The indicators change only when it completes and stay unchanged while it runs.
- R11: Synchronous reset clears `sample_o`, the delay line, the accumulator and the arming flag, and drives both indicators to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high (also used in the serial domain) |
| ser_clk | input | 1 | Serial bit clock |
| ser_hs | input | 1 | Handshake: high while bits are shifted in, low to request evaluation |
| ser_bit | input | 1 | Serial data bit |
| sample_o | output | SW | Assembled sample |
| ind_hi_o | output | 1 | First indicator |
| ind_alt_o | output | 1 | Second indicator |

## Verification
Two functions can coincide: shifting in a new sample and accumulating the previous one. The bench lowers the handshake and, four system clocks later, raises it again and shifts the next word while the multiply-accumulate is still running. This re-arms the engine in the middle of an evaluation. The bench judges the overlap by checking that the first result matches the reference model while the second word is still arriving. It then checks that the second evaluation starts only after the first has finished and produces the model's result for the delay line holding both samples.

// File: rtl/fir_cls_pkg.sv
package fir_cls_pkg;
    localparam int COEF_W = 17;
    localparam int ACC_W  = 32;
    localparam int LVL_LSB = 15;
    localparam int LVL_W  = 8;

    typedef struct packed {
        logic hi;
        logic alt;
    } ind_t;

    // Symmetric triangular coefficient profile, scaled by 2^15.
    function automatic logic signed [COEF_W-1:0] coef_at(int k, int n, int base, int step);
        int d;
        d = (k < n - 1 - k) ? k : n - 1 - k;
        return COEF_W'(base + step * d);
    endfunction
endpackage

// File: rtl/fir_ser_capture.sv
module fir_ser_capture #(
    parameter int SW = 10
) (
    input  logic          ser_clk,
    input  logic          rst,
    input  logic          ser_en,
    input  logic          ser_bit,
    output logic [SW-1:0] sample_o
);
    logic [SW-1:0] sample_d, sample_q;

    always_comb begin
        sample_d = sample_q;
        if (ser_en) sample_d = {ser_bit, sample_q[SW-1:1]};
    end

    always_ff @(posedge ser_clk) begin
        if (rst) sample_q <= '0;
        else     sample_q <= sample_d;
    end

    assign sample_o = sample_q;
endmodule

// File: rtl/fir_hs_sync.sv
module fir_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb chain_d = {chain_q[STAGES-2:0], async_i};

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
    import fir_cls_pkg::*;
#(
    parameter int NTAPS     = 8,
    parameter int SW        = 10,
    parameter int COEF_BASE = 2048,
    parameter int COEF_STEP = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hs_s,
    input  logic [SW-1:0]           sample_i,
    output logic                    start_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    filled_o,
    output logic signed [ACC_W-1:0] result_o
);
    localparam int IDX_W  = (NTAPS > 1) ? $clog2(NTAPS) : 1;
    localparam int FILL_W = $clog2(NTAPS + 1);
    localparam int PROD_W = COEF_W + SW + 1;

    typedef struct packed {
        logic [NTAPS-1:0][SW-1:0] line;
        logic signed [ACC_W-1:0]  acc;
        logic [IDX_W-1:0]         idx;
        logic                     busy;
        logic                     armed;
        logic [FILL_W-1:0]        fill;
    } mac_st_t;

    mac_st_t st_d, st_q;
    logic signed [COEF_W-1:0] coef_cur;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_sum;
    logic start, fin;

    always_comb begin
        st_d     = st_q;
        fin      = 1'b0;
        start    = !hs_s && st_q.armed && !st_q.busy;
        coef_cur = coef_at(int'(st_q.idx), NTAPS, COEF_BASE, COEF_STEP);
        prod     = coef_cur * $signed({1'b0, st_q.line[st_q.idx]});
        acc_sum  = st_q.acc + ACC_W'(prod);
        if (hs_s) st_d.armed = 1'b1;
        if (start) begin
            st_d.line  = {st_q.line[NTAPS-2:0], sample_i};
            st_d.acc   = '0;
            st_d.idx   = '0;
            st_d.busy  = 1'b1;
            st_d.armed = 1'b0;
            if (st_q.fill < FILL_W'(NTAPS)) st_d.fill = st_q.fill + 1'b1;
        end else if (st_q.busy) begin
            st_d.acc = acc_sum;
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == IDX_W'(NTAPS - 1)) begin
                st_d.busy = 1'b0;
                fin       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign start_o  = start;
    assign busy_o   = st_q.busy;
    assign done_o   = fin;
    assign filled_o = (st_q.fill == FILL_W'(NTAPS));
    assign result_o = acc_sum;
endmodule

// File: rtl/fir_level_band.sv
module fir_level_band #(
    parameter int LVL_W    = 8,
    parameter int LOW_MIN  = 40,
    parameter int LOW_MAX  = 60,
    parameter int HIGH_MIN = 90,
    parameter int HIGH_MAX = 110
) (
    input  logic signed [LVL_W-1:0] level_i,
    input  logic                    filled_i,
    output logic                    hi_o,
    output logic                    alt_o
);
    localparam logic signed [LVL_W-1:0] LO_A = LVL_W'(LOW_MIN);
    localparam logic signed [LVL_W-1:0] LO_B = LVL_W'(LOW_MAX);
    localparam logic signed [LVL_W-1:0] HI_A = LVL_W'(HIGH_MIN);
    localparam logic signed [LVL_W-1:0] HI_B = LVL_W'(HIGH_MAX);

    always_comb begin
        hi_o  = 1'b0;
        alt_o = 1'b1;
        if (filled_i) begin
            if (level_i >= LO_A && level_i <= LO_B) begin
                alt_o = 1'b0;
            end else if (level_i >= HI_A && level_i <= HI_B) begin
                hi_o  = 1'b1;
                alt_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/fir_level_classifier.sv
module fir_level_classifier
    import fir_cls_pkg::*;
#(
    parameter int NTAPS     = 8,
    parameter int SW        = 10,
    parameter int COEF_BASE = 2048,
    parameter int COEF_STEP = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_clk,
    input  logic          ser_hs,
    input  logic          ser_bit,
    output logic [SW-1:0] sample_o,
    output logic          ind_hi_o,
    output logic          ind_alt_o
);
    logic hs_s_w, start_w, busy_w, done_w, filled_w;
    logic signed [ACC_W-1:0] result_w;
    logic signed [LVL_W-1:0] level_w;
    logic band_hi, band_alt;
    ind_t ind_d, ind_q;

    fir_ser_capture #(.SW(SW)) u_cap (
        .ser_clk (ser_clk),
        .rst     (rst),
        .ser_en  (ser_hs),
        .ser_bit (ser_bit),
        .sample_o(sample_o)
    );

    fir_hs_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(ser_hs),
        .sync_o (hs_s_w)
    );

    fir_mac_engine #(
        .NTAPS(NTAPS), .SW(SW), .COEF_BASE(COEF_BASE), .COEF_STEP(COEF_STEP)
    ) u_mac (
        .clk     (clk),
        .rst     (rst),
        .hs_s    (hs_s_w),
        .sample_i(sample_o),
        .start_o (start_w),
        .busy_o  (busy_w),
        .done_o  (done_w),
        .filled_o(filled_w),
        .result_o(result_w)
    );

    assign level_w = result_w[LVL_LSB +: LVL_W];

    fir_level_band #(.LVL_W(LVL_W)) u_band (
        .level_i (level_w),
        .filled_i(filled_w),
        .hi_o    (band_hi),
        .alt_o   (band_alt)
    );

    always_comb begin
        ind_d = ind_q;
        if (done_w) begin
            ind_d.hi  = band_hi;
            ind_d.alt = band_alt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ind_q <= '0;
        else     ind_q <= ind_d;
    end

    assign ind_hi_o  = ind_q.hi;
    assign ind_alt_o = ind_q.alt;
endmodule

// File: rtl/fir_level_classifier_chk.sv
module fir_level_classifier_chk (
    input logic clk,
    input logic rst,
    input logic hs_s,
    input logic start,
    input logic busy,
    input logic ind_hi,
    input logic ind_alt
);
    logic seen_high;

    always_ff @(posedge clk) begin
        if (rst)        seen_high <= 1'b0;
        else if (start) seen_high <= 1'b0;
        else if (hs_s)  seen_high <= 1'b1;
    end

    p_ind_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(ind_hi && ind_alt));

    p_one_shot_r3: assert property (@(posedge clk) disable iff (rst)
        start |-> seen_high);

    p_start_when_low_r3: assert property (@(posedge clk) disable iff (rst)
        start |-> !hs_s);

    p_no_restart_busy_r10: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    p_ind_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({ind_hi, ind_alt}));

    p_reset_clear_r11: assert property (@(posedge clk)
        $past(rst) |-> (!ind_hi && !ind_alt));
endmodule

bind fir_level_classifier fir_level_classifier_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .hs_s   (hs_s_w),
    .start  (start_w),
    .busy   (busy_w),
    .ind_hi (ind_hi_o),
    .ind_alt(ind_alt_o)
);

// File: tb/fir_level_classifier_tb.sv
module fir_level_classifier_tb;
    localparam int N  = 8;
    localparam int SW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_hs = 1'b0;
    logic ser_bit = 1'b0;
    logic [SW-1:0] sample_o;
    logic ind_hi_o, ind_alt_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int mline [N];
    int mfill = 0;
    logic exp_hi = 1'b0;
    logic exp_alt = 1'b0;

    always #5 clk = ~clk;

    fir_level_classifier #(.NTAPS(N), .SW(SW)) u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_hs(ser_hs),
        .ser_bit(ser_bit), .sample_o(sample_o),
        .ind_hi_o(ind_hi_o), .ind_alt_o(ind_alt_o)
    );

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int coef_m(int k);
        int d;
        d = (k < N - 1 - k) ? k : N - 1 - k;
        return 2048 + 1024 * d;
    endfunction

    task automatic model_push(int v);
        longint acc;
        logic [31:0] a;
        logic signed [7:0] lv;
        for (int k = N - 1; k > 0; k--) mline[k] = mline[k-1];
        mline[0] = v;
        if (mfill < N) mfill++;
        acc = 0;
        for (int k = 0; k < N; k++) acc += longint'(coef_m(k)) * mline[k];
        a  = 32'(acc);
        lv = a[22:15];
        if (mfill < N) begin exp_hi = 0; exp_alt = 1; end
        else if (lv >= 40 && lv <= 60) begin exp_hi = 0; exp_alt = 0; end
        else if (lv >= 90 && lv <= 110) begin exp_hi = 1; exp_alt = 0; end
        else begin exp_hi = 0; exp_alt = 1; end
    endtask

    task automatic shift_bits(int v);
        ser_hs = 1'b1;
        for (int i = 0; i < SW; i++) begin
            ser_bit = v[i];
            #2 ser_clk = 1'b1;
            #5 ser_clk = 1'b0;
            #3;
        end
        repeat (3) @(negedge clk);
        check("R1 assembled sample", int'(sample_o), v);
    endtask

    task automatic drop_and_eval(int v, int extra, string tag);
        logic ph, pa;
        @(negedge clk);
        ser_hs = 1'b0;
        ph = exp_hi; pa = exp_alt;
        model_push(v);
        repeat (N) @(negedge clk);
        check("R10 hold during evaluation", int'({ind_hi_o, ind_alt_o}), int'({ph, pa}));
        repeat (6 + extra) @(negedge clk);
        check(tag, int'({ind_hi_o, ind_alt_o}), int'({exp_hi, exp_alt}));
    endtask

    task automatic send(int v, string tag);
        shift_bits(v);
        drop_and_eval(v, 0, tag);
    endtask

    task automatic t_reset();
        check("R11 reset sample", int'(sample_o), 0);
        check("R11 reset indicators", int'({ind_hi_o, ind_alt_o}), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < N - 1; i++) begin
            send(57, "R9 not yet filled");
            check("R9 second indicator while filling", int'({ind_hi_o, ind_alt_o}), 1);
        end
        send(57, "R6 level 49 after fill");
        check("R6 low band code", int'({ind_hi_o, ind_alt_o}), 0);
    endtask

    task automatic t_ignore();
        logic [SW-1:0] held;
        send(10'h2A5, "R8 level outside bands");
        held = sample_o;
        check("R1 LSB-first word", int'(held), 10'h2A5);
        ser_bit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #2 ser_clk = 1'b1;
            #5 ser_clk = 1'b0;
            #3;
        end
        repeat (8) @(negedge clk);
        check("R2 sample unchanged with handshake low", int'(sample_o), int'(held));
        check("R2 indicators unchanged", int'({ind_hi_o, ind_alt_o}), int'({exp_hi, exp_alt}));
    endtask

    task automatic t_level(int v, int code, string tag);
        for (int i = 0; i < N; i++) send(v, tag);
        check(tag, int'({ind_hi_o, ind_alt_o}), code);
    endtask

    task automatic t_order();
        for (int i = 0; i < N; i++) send(0, "R4 zero fill");
        send(650, "R4 newest tap");
        check("R4 tap0 level 40", int'({ind_hi_o, ind_alt_o}), 0);
        send(0, "R4 tap1");
        check("R4 tap1 level 60", int'({ind_hi_o, ind_alt_o}), 0);
        send(0, "R4 tap2");
        check("R4 tap2 level 81", int'({ind_hi_o, ind_alt_o}), 1);
        send(0, "R4 tap3");
        check("R4 tap3 level 101", int'({ind_hi_o, ind_alt_o}), 2);
    endtask

    task automatic t_one_shot();
        for (int i = 0; i < N; i++) send(57, "R3 refill");
        shift_bits(219);
        drop_and_eval(219, 3 * N, "R3 single evaluation in long low period");
        check("R3 level 60 not 75", int'({ind_hi_o, ind_alt_o}), 0);
        send(57, "R3 re-armed after handshake high");
    endtask

    task automatic t_overlap();
        logic h1, a1;
        shift_bits(115);
        @(negedge clk);
        ser_hs = 1'b0;
        model_push(115);
        h1 = exp_hi; a1 = exp_alt;
        repeat (4) @(negedge clk);
        shift_bits(300);
        check("R10 first result during overlap", int'({ind_hi_o, ind_alt_o}), int'({h1, a1}));
        drop_and_eval(300, 0, "R3 second evaluation after overlap");
    endtask

    initial begin
        repeat (3) begin
            #2 ser_clk = 1'b1;
            #5 ser_clk = 1'b0;
            #3;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_fill();
        t_ignore();
        t_level(46, 0, "R6 lower edge level 40");
        t_level(45, 1, "R8 level 39");
        t_level(69, 0, "R6 upper edge level 60");
        t_level(70, 1, "R8 level 61");
        t_level(103, 2, "R7 lower edge level 90");
        t_level(102, 1, "R8 level 89");
        t_level(126, 2, "R7 upper edge level 110");
        t_level(127, 1, "R8 level 111");
        t_level(407, 2, "R5 wrapped level 100");
        t_order();
        t_one_shot();
        t_overlap();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule